// File: doc/BRIEF.md
# Look-Ahead Pulse Timestamp Pipeline

This block holds timestamps for the beam pulse now in progress and for the three pulses that follow it. Each slot holds a seconds word, a nanoseconds word and a 32-bit status word. The low 17 bits of the nanoseconds word carry a pulse ID. The code 0x1FFFF is reserved to mean that no valid ID is present.

Each fiducial strobe moves every slot one step closer to "current". The timestamp waiting at the input enters the slot for the pulse furthest ahead. Once the strobe has been applied, the block checks the table. It looks for missing IDs, for neighbours whose IDs are not consecutive, and for a look-ahead that has stalled on one repeated ID. Each kind of error has its own saturating counter. A per-pulse error flag summarises the result.

The table is filled with system time at reset, and every slot starts with invalid status.

Top module: `pulse_ts_pipe`

## Requirements
- R1: While rst_ni is low, every slot takes sys_sec_i and sys_nsec_i with status 0xFFFFFFFF. Both counters, err_o and dup_o are 0.
- R2: In a cycle without fid_i, no slot, counter or flag changes, even if the timestamp inputs change.
- R3: On a clock edge with fid_i high, slot k takes the old contents of slot k+1 (k = 2, 1, 0). Slot 3 takes the new timestamp, with sec_o[3] = ts_sec_i.
- R4: The pulse ID of a slot is nsec[16:0]. When ts_vld_i is low on a strobe, slot 3 gets nsec[31:17] from ts_nsec_i and nsec[16:0] = 0x1FFFF.
- R5: On each strobe where any slot of the shifted table holds ID 0x1FFFF, bad_cnt_o increases by one.
- R6: On each strobe where any neighbouring pair of slots (k, k+1) holds two valid IDs with ID[k+1] != ID[k]+1, gap_cnt_o increases by one. The successor of 0x1FFFE is 0.
- R7: err_o is updated on every strobe. It is 1 if that strobe met the condition of R5 or R6, and 0 otherwise.
- R8: dup_o is updated on every strobe. It is 1 when slots 1, 2 and 3 of the shifted table hold equal IDs.
- R9: The status of slot 3 is 0 only when ts_vld_i is high, the new ID is not 0x1FFFF and dup_o is not set by the same strobe. Otherwise it is 0xFFFFFFFF.
- R10: Each counter stops at its all-ones value (CNT_W bits, default 16) and holds there.
- R11: A single strobe can raise bad_cnt_o and gap_cnt_o together, each by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fid_i | input | 1 | Fiducial strobe, one cycle wide |
| ts_sec_i | input | 32 | Incoming seconds word |
| ts_nsec_i | input | 32 | Incoming nanoseconds word, pulse ID in [16:0] |
| ts_vld_i | input | 1 | Incoming timestamp is valid |
| sys_sec_i | input | 32 | System seconds used at reset |
| sys_nsec_i | input | 32 | System nanoseconds used at reset |
| sec_o | output | DEPTH x 32 | Seconds word per slot, index 0 = current |
| nsec_o | output | DEPTH x 32 | Nanoseconds word per slot |
| stat_o | output | DEPTH x 32 | Status per slot, 0 = OK, all-ones = invalid |
| bad_cnt_o | output | CNT_W | Strobes that found an invalid ID |
| gap_cnt_o | output | CNT_W | Strobes that found a non-consecutive pair |
| err_o | output | 1 | Latest strobe found an error |
| dup_o | output | 1 | Latest strobe found a stalled look-ahead |

## Verification
Two things can happen in the same cycle. The invalid-ID counter and the continuity counter can both step on one strobe. The stall detector can also fire while continuity breaks.

The bench walks a sequence of IDs to create these cases. An invalid marker is shifted in behind a valid pair that has a gap, so both counters see the same strobe. A repeated ID is held for three strobes, so the stall and the gap fall on the same strobe. On that strobe, the bench checks that each counter moved by exactly one, and it checks that err_o and the status of slot 3 agree with the flags. A wrap from 0x1FFFE to 0 is included to show that no gap is counted there.

// File: rtl/ts_pipe_pkg.sv
package ts_pipe_pkg;
  localparam int WORD_W = 32;
  localparam int PID_W  = 17;

  localparam logic [PID_W-1:0]  PID_BAD  = '1;
  localparam logic [PID_W-1:0]  PID_LAST = {{(PID_W-1){1'b1}}, 1'b0};
  localparam logic [WORD_W-1:0] STAT_OK  = '0;
  localparam logic [WORD_W-1:0] STAT_BAD = '1;

  typedef struct packed {
    logic [WORD_W-1:0] sec;
    logic [WORD_W-1:0] nsec;
    logic [WORD_W-1:0] stat;
  } ts_entry_t;

  function automatic logic [PID_W-1:0] pid_next(input logic [PID_W-1:0] p);
    return (p == PID_LAST) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/ts_pid_check.sv
module ts_pid_check
  import ts_pipe_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0][PID_W-1:0] pid_i,
  output logic                        bad_o,
  output logic                        gap_o,
  output logic                        dup_o
);
  logic [DEPTH-1:0] bad_v;
  logic [DEPTH-2:0] gap_v;
  logic [DEPTH-3:0] eq_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_bad
    assign bad_v[g] = (pid_i[g] == PID_BAD);
  end

  // pairs with a missing ID are left to the invalid counter
  for (genvar g = 0; g < DEPTH-1; g++) begin : g_gap
    assign gap_v[g] = !bad_v[g] && !bad_v[g+1] &&
                      (pid_i[g+1] != pid_next(pid_i[g]));
  end

  // look-ahead slots 1..DEPTH-1 all equal
  for (genvar g = 0; g < DEPTH-2; g++) begin : g_eq
    assign eq_v[g] = (pid_i[g+1] == pid_i[g+2]);
  end

  assign bad_o = |bad_v;
  assign gap_o = |gap_v;
  assign dup_o = &eq_v;
endmodule

// File: rtl/ts_sat_cnt.sv
module ts_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R10
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R2
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/ts_entry_pipe.sv
module ts_entry_pipe
  import ts_pipe_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   adv_i,
  input  ts_entry_t              new_i,
  input  logic [WORD_W-1:0]      sys_sec_i,
  input  logic [WORD_W-1:0]      sys_nsec_i,
  output ts_entry_t [DEPTH-1:0]  tab_o
);
  ts_entry_t [DEPTH-1:0] tab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        tab_q[i].sec  <= sys_sec_i;
        tab_q[i].nsec <= sys_nsec_i;
        tab_q[i].stat <= STAT_BAD;
      end
    end else if (adv_i) begin
      for (int i = 0; i < DEPTH-1; i++) tab_q[i] <= tab_q[i+1];
      tab_q[DEPTH-1] <= new_i;
    end
  end

  assign tab_o = tab_q;

  // R3
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (tab_q[0] == $past(tab_q[1])));

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (tab_q[DEPTH-1] == $past(new_i)));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(tab_q));
endmodule

// File: rtl/pulse_ts_pipe.sv
module pulse_ts_pipe
  import ts_pipe_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           fid_i,
  input  logic [31:0]                    ts_sec_i,
  input  logic [31:0]                    ts_nsec_i,
  input  logic                           ts_vld_i,
  input  logic [31:0]                    sys_sec_i,
  input  logic [31:0]                    sys_nsec_i,
  output logic [DEPTH-1:0][31:0]         sec_o,
  output logic [DEPTH-1:0][31:0]         nsec_o,
  output logic [DEPTH-1:0][31:0]         stat_o,
  output logic [CNT_W-1:0]               bad_cnt_o,
  output logic [CNT_W-1:0]               gap_cnt_o,
  output logic                           err_o,
  output logic                           dup_o
);
  ts_entry_t [DEPTH-1:0]      tab;
  ts_entry_t                  new_ent;
  logic [WORD_W-1:0]          new_nsec;
  logic [WORD_W-1:0]          new_stat;
  logic [DEPTH-1:0][PID_W-1:0] nxt_pid;
  logic                       bad, gap, dup;
  logic                       err_q, dup_q;

  // R4: missing timestamp carries the reserved ID
  assign new_nsec = ts_vld_i ? ts_nsec_i : {ts_nsec_i[WORD_W-1:PID_W], PID_BAD};

  // IDs of the table as it will be after this strobe
  for (genvar g = 0; g < DEPTH-1; g++) begin : g_nxt
    assign nxt_pid[g] = tab[g+1].nsec[PID_W-1:0];
  end
  assign nxt_pid[DEPTH-1] = new_nsec[PID_W-1:0];

  ts_pid_check #(.DEPTH(DEPTH)) u_check (
    .pid_i (nxt_pid),
    .bad_o (bad),
    .gap_o (gap),
    .dup_o (dup)
  );

  // R9
  assign new_stat = (ts_vld_i && new_nsec[PID_W-1:0] != PID_BAD && !dup) ? STAT_OK : STAT_BAD;

  assign new_ent.sec  = ts_sec_i;
  assign new_ent.nsec = new_nsec;
  assign new_ent.stat = new_stat;

  ts_entry_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (fid_i),
    .new_i      (new_ent),
    .sys_sec_i  (sys_sec_i),
    .sys_nsec_i (sys_nsec_i),
    .tab_o      (tab)
  );

  ts_sat_cnt #(.CNT_W(CNT_W)) u_bad_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (fid_i && bad),
    .cnt_o  (bad_cnt_o)
  );

  ts_sat_cnt #(.CNT_W(CNT_W)) u_gap_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (fid_i && gap),
    .cnt_o  (gap_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      dup_q <= 1'b0;
    end else if (fid_i) begin
      err_q <= bad || gap;
      dup_q <= dup;
    end
  end

  assign err_o = err_q;
  assign dup_o = dup_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign sec_o[g]  = tab[g].sec;
    assign nsec_o[g] = tab[g].nsec;
    assign stat_o[g] = tab[g].stat;
  end

  // R7
  err_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_cnt_o != $past(bad_cnt_o)) |-> err_o);

  // R7
  err_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_cnt_o != $past(gap_cnt_o)) |-> err_o);

  // R8
  dup_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_o |-> (stat_o[DEPTH-1] == STAT_BAD));
endmodule

// File: tb/pulse_ts_pipe_tb.sv
`timescale 1ns/1ps
module pulse_ts_pipe_tb;
  localparam int DEPTH = 4;
  localparam int CNT_W = 4;
  localparam int NVEC  = 21;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   fid_i = 1'b0;
  logic [31:0]            ts_sec_i = '0, ts_nsec_i = '0;
  logic                   ts_vld_i = 1'b0;
  logic [31:0]            sys_sec_i = 32'h1111_1111, sys_nsec_i = 32'h1234_5678;
  logic [DEPTH-1:0][31:0] sec_o, nsec_o, stat_o;
  logic [CNT_W-1:0]       bad_cnt_o, gap_cnt_o;
  logic                   err_o, dup_o;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_ts_pipe #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fid_i(fid_i),
    .ts_sec_i(ts_sec_i), .ts_nsec_i(ts_nsec_i), .ts_vld_i(ts_vld_i),
    .sys_sec_i(sys_sec_i), .sys_nsec_i(sys_nsec_i),
    .sec_o(sec_o), .nsec_o(nsec_o), .stat_o(stat_o),
    .bad_cnt_o(bad_cnt_o), .gap_cnt_o(gap_cnt_o), .err_o(err_o), .dup_o(dup_o)
  );

  // row: {vld, pid[16:0], exp_bad_step, exp_gap_step, exp_dup}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 17'h00100, 3'b010}, {1'b1, 17'h00101, 3'b010},
    {1'b1, 17'h00102, 3'b010}, {1'b1, 17'h00103, 3'b000},
    {1'b1, 17'h00104, 3'b000}, {1'b0, 17'h00105, 3'b100},
    {1'b1, 17'h00106, 3'b100}, {1'b1, 17'h00107, 3'b100},
    {1'b1, 17'h00108, 3'b100}, {1'b1, 17'h00109, 3'b000},
    {1'b1, 17'h00109, 3'b010}, {1'b1, 17'h00109, 3'b011},
    {1'b1, 17'h00110, 3'b010}, {1'b1, 17'h1FFFD, 3'b010},
    {1'b1, 17'h1FFFE, 3'b010}, {1'b1, 17'h00000, 3'b010},
    {1'b1, 17'h00001, 3'b000}, {1'b1, 17'h00002, 3'b000},
    {1'b1, 17'h1FFFF, 3'b100}, {1'b1, 17'h00050, 3'b100},
    {1'b1, 17'h00060, 3'b110}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic vld, input logic [31:0] sec, input logic [31:0] nsec);
    @(negedge clk);
    ts_vld_i = vld; ts_sec_i = sec; ts_nsec_i = nsec; fid_i = 1'b1;
    @(negedge clk);
    fid_i = 1'b0;
  endtask

  task automatic check_reset_state(input logic [31:0] s, input logic [31:0] n);
    for (int i = 0; i < DEPTH; i++) begin
      check(sec_o[i] == s, "R1 sec", sec_o[i], s);
      check(nsec_o[i] == n, "R1 nsec", nsec_o[i], n);
      check(stat_o[i] == 32'hFFFF_FFFF, "R1 stat", stat_o[i], 32'hFFFF_FFFF);
    end
    check(bad_cnt_o == 0, "R1 bad_cnt", 32'(bad_cnt_o), 0);
    check(gap_cnt_o == 0, "R1 gap_cnt", 32'(gap_cnt_o), 0);
    check(err_o == 0 && dup_o == 0, "R1 flags", {30'd0, err_o, dup_o}, 0);
  endtask

  initial begin
    logic [31:0] hsec [NVEC];
    logic [31:0] hnsec [NVEC];
    int eb = 0, eg = 0;
    repeat (3) @(negedge clk);
    check_reset_state(32'h1111_1111, 32'h1234_5678);
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state(32'h1111_1111, 32'h1234_5678);

    for (int k = 0; k < NVEC; k++) begin
      logic vld; logic [16:0] pid; logic sb, sg, sd;
      logic [31:0] sec, nsec, exp_n, exp_s;
      {vld, pid, sb, sg, sd} = VEC[k];
      sec   = 32'h1000 + 32'(k);
      nsec  = {15'(k), pid};
      exp_n = vld ? nsec : {15'(k), 17'h1FFFF};
      exp_s = (vld && pid != 17'h1FFFF && !sd) ? 32'h0 : 32'hFFFF_FFFF;
      hsec[k] = sec; hnsec[k] = exp_n;
      strobe(vld, sec, nsec);
      eb += int'(sb); eg += int'(sg);
      check(sec_o[3] == sec, "R3 load sec", sec_o[3], sec);
      check(nsec_o[3] == exp_n, "R4 nsec/pid", nsec_o[3], exp_n);
      if (k >= 3) begin
        check(sec_o[0] == hsec[k-3], "R3 shift sec", sec_o[0], hsec[k-3]);
        check(nsec_o[0] == hnsec[k-3], "R3 shift nsec", nsec_o[0], hnsec[k-3]);
      end
      check(bad_cnt_o == CNT_W'(eb), "R5 R11 bad_cnt", 32'(bad_cnt_o), 32'(eb));
      check(gap_cnt_o == CNT_W'(eg), "R6 R11 gap_cnt", 32'(gap_cnt_o), 32'(eg));
      check(err_o == (sb | sg), "R7 err", 32'(err_o), 32'(sb | sg));
      check(dup_o == sd, "R8 dup", 32'(dup_o), 32'(sd));
      check(stat_o[3] == exp_s, "R9 stat3", stat_o[3], exp_s);
    end

    // R2: input changes without a strobe leave everything alone
    begin
      logic [31:0] s3, n0; logic [CNT_W-1:0] bc;
      s3 = sec_o[3]; n0 = nsec_o[0]; bc = bad_cnt_o;
      ts_sec_i = 32'hDEAD_BEEF; ts_nsec_i = 32'h0; ts_vld_i = 1'b0;
      repeat (4) @(negedge clk);
      check(sec_o[3] == s3, "R2 hold sec3", sec_o[3], s3);
      check(nsec_o[0] == n0, "R2 hold nsec0", nsec_o[0], n0);
      check(bad_cnt_o == bc, "R2 hold cnt", 32'(bad_cnt_o), 32'(bc));
    end

    // R10: drive the invalid counter past its limit (7 + 10 steps, 4-bit)
    for (int k = 0; k < 10; k++) strobe(1'b0, 32'h2000, 32'h0);
    check(bad_cnt_o == 4'hF, "R10 saturate", 32'(bad_cnt_o), 32'hF);
    strobe(1'b0, 32'h2001, 32'h0);
    check(bad_cnt_o == 4'hF, "R10 stays", 32'(bad_cnt_o), 32'hF);

    // R1: reset mid-run reloads system time
    @(negedge clk);
    sys_sec_i = 32'h5555_0000; sys_nsec_i = 32'h0000_0042;
    rst_ni = 1'b0;
    @(negedge clk);
    check_reset_state(32'h5555_0000, 32'h0000_0042);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule